// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits inside a coprocessor that shares an instruction stream with a host CPU. The coprocessor never fetches code itself. Every byte the host reads from memory is copied into a small shadow queue here. The host's 2-bit queue-status code then says what the host's decoder did with its own queue in each cycle. Replaying that code on the shadow queue keeps the two queues aligned byte for byte.

When the host takes the first byte of an instruction, the tracker removes that byte from its shadow queue. It then checks whether the top five bits carry the escape pattern 11011, which marks an instruction meant for the coprocessor. Any further bytes the host takes from the same instruction are handed to the coprocessor on a byte stream with a valid strobe, but only if that check matched. Instructions without the escape pattern pass through the queue and have no effect.

Two sticky error flags report when the host status and the fetch stream disagree: one for a write into a full queue, one for a pop from an empty queue.

Top module: `coproc_queue_tracker`

## Requirements
- R1: Fetched bytes leave the shadow queue in the order they were written.
- R2: Status 00 neither pops nor flushes. A simultaneous fetch is still written.
- R3: Status 01 pops the head byte. `escHit` is high in the next cycle exactly when bits [7:3] of that byte equal 11011.
- R4: Status 10 empties the queue, drops a fetch in the same cycle, and clears the escape match.
- R5: Status 11 after a matching first byte pops the head byte. That byte appears on `coByte` with `coValid` high in the next cycle.
- R6: Status 11 without a current match still pops the head byte, but `coValid` stays low.
- R7: The escape match stays set across any number of status-11 pops. It is cleared by every status-01 pop whose byte does not match.
- R8: The queue holds 6 bytes. A fetch into a full queue with no pop in the same cycle is dropped and sets the sticky `ovfErr`.
- R9: A status-01 or status-11 pop on an empty queue sets the sticky `udfErr`. It produces no `coValid` and no `escHit`.
- R10: After reset, `escHit`, `coValid`, `ovfErr` and `udfErr` are low and the queue is empty.
- R11: A fetch and a pop in the same cycle on a full queue are both accepted, and `ovfErr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | Host fetched a code byte this cycle |
| fetchByte | input | 8 | The fetched byte |
| qStatus | input | 2 | Host queue status: 00 idle, 01 first byte, 10 flush, 11 next byte |
| escHit | output | 1 | One-cycle pulse: the popped first byte carried the escape pattern |
| coValid | output | 1 | One-cycle strobe: `coByte` holds a coprocessor instruction byte |
| coByte | output | 8 | Coprocessor instruction byte |
| ovfErr | output | 1 | Sticky: a fetch hit a full queue |
| udfErr | output | 1 | Sticky: a pop found the queue empty |

## Verification
The assertions assume that `qStatus` and `fetchValid` are settled at every rising clock edge. They make no assumption that the host keeps within the queue depth: the overflow and underflow properties are written to hold in exactly the cases where the host breaks that assumption. Inputs change only on falling edges. Each sweep iteration pushes two bytes and pops two, so the queue returns to empty and the error flags stay low until the final sequence, which overruns the queue and then underruns it on purpose.

// File: rtl/cqt_pkg.sv
package cqt_pkg;
  typedef enum logic [1:0] {
    Q_IDLE  = 2'b00,
    Q_FIRST = 2'b01,
    Q_FLUSH = 2'b10,
    Q_NEXT  = 2'b11
  } qstat_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic emit;
  } qctl_t;
endpackage

// File: rtl/cqt_dpath.sv
module cqt_dpath
  import cqt_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter int WIDTH   = 8,
  parameter int PAT_W   = 5,
  parameter logic [PAT_W-1:0] ESC_PAT = 5'b11011
) (
  input  logic             clk,
  input  logic             rst,
  input  qctl_t            ctl,
  input  logic [WIDTH-1:0] fetchByte,
  output logic             headIsEsc,
  output logic [WIDTH-1:0] coByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [WIDTH-1:0] headByte;

  assign headByte  = slot[rdPtr];
  assign headIsEsc = (headByte[WIDTH-1 -: PAT_W] == ESC_PAT);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot[g] <= '0;
      else if (ctl.push && wrPtr == PTR_W'(g)) slot[g] <= fetchByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) coByte <= '0;
    else if (ctl.emit) coByte <= headByte;
  end

  // R4: after a flush both pointers meet at slot zero
  p_flush_align_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.flush |=> (rdPtr == '0 && wrPtr == '0));

  // R1: pointers only ever step by one slot with wrap
  p_rd_step_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl.pop && !ctl.flush) |=> (rdPtr == bump($past(rdPtr))));
endmodule

// File: rtl/cqt_ctrl.sv
module cqt_ctrl
  import cqt_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fetchValid,
  input  logic [1:0] qStatus,
  input  logic       headIsEsc,
  output qctl_t      ctl,
  output logic       escHit,
  output logic       coValid,
  output logic       ovfErr,
  output logic       udfErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  qstat_e qs;
  logic [CNT_W-1:0] count, cntNext;
  logic escMatch;
  logic isEmpty, isFull, popReq, popOk, ovfEvt, udfEvt;

  assign qs      = qstat_e'(qStatus);
  assign isEmpty = (count == '0);
  assign isFull  = (count == FULL_C);
  assign popReq  = (qs == Q_FIRST) || (qs == Q_NEXT);
  assign popOk   = popReq && !isEmpty;
  assign udfEvt  = popReq && isEmpty;
  assign ovfEvt  = fetchValid && (qs != Q_FLUSH) && isFull && !popOk;

  always_comb begin
    ctl.flush = (qs == Q_FLUSH);
    ctl.pop   = popOk;
    ctl.push  = fetchValid && !ctl.flush && (!isFull || popOk);
    ctl.emit  = (qs == Q_NEXT) && popOk && escMatch;
  end

  always_comb begin
    cntNext = count;
    if (ctl.flush)                 cntNext = '0;
    else if (ctl.push && !popOk)   cntNext = count + ONE;
    else if (!ctl.push && popOk)   cntNext = count - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      escMatch <= 1'b0;
      escHit   <= 1'b0;
      coValid  <= 1'b0;
      ovfErr   <= 1'b0;
      udfErr   <= 1'b0;
    end else begin
      count   <= cntNext;
      escHit  <= (qs == Q_FIRST) && popOk && headIsEsc;
      coValid <= ctl.emit;
      if (ctl.flush)          escMatch <= 1'b0;
      else if (qs == Q_FIRST) escMatch <= popOk && headIsEsc;
      if (ovfEvt) ovfErr <= 1'b1;
      if (udfEvt) udfErr <= 1'b1;
    end
  end

  // R8: occupancy never exceeds the depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_C);

  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovfErr |=> ovfErr);

  // R4: flush leaves an empty queue and no match
  p_flush_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (qStatus == 2'b10) |=> (count == '0 && !escMatch));

  // R6: no coprocessor byte without a live match
  p_no_emit_nomatch_r6: assert property (@(posedge clk) disable iff (rst)
    (qStatus == 2'b11 && !escMatch) |=> !coValid);

  // R9: empty pop flags underflow and yields nothing
  p_udf_r9: assert property (@(posedge clk) disable iff (rst)
    (popReq && count == '0) |=> (udfErr && !coValid && !escHit));

  // R2: idle status with no fetch keeps occupancy
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (qStatus == 2'b00 && !fetchValid) |=> $stable(count));

  // R11: full queue with simultaneous pop and fetch does not overflow
  p_full_swap_r11: assert property (@(posedge clk) disable iff (rst)
    (isFull && fetchValid && qStatus[0] && !ovfErr) |=> !ovfErr);
endmodule

// File: rtl/coproc_queue_tracker.sv
module coproc_queue_tracker
  import cqt_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  parameter int PAT_W = 5,
  parameter logic [PAT_W-1:0] ESC_PAT = 5'b11011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetchValid,
  input  logic [WIDTH-1:0] fetchByte,
  input  logic [1:0]       qStatus,
  output logic             escHit,
  output logic             coValid,
  output logic [WIDTH-1:0] coByte,
  output logic             ovfErr,
  output logic             udfErr
);
  qctl_t ctl;
  logic  headIsEsc;

  cqt_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .qStatus(qStatus),
    .headIsEsc(headIsEsc), .ctl(ctl), .escHit(escHit), .coValid(coValid),
    .ovfErr(ovfErr), .udfErr(udfErr)
  );

  cqt_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PAT_W(PAT_W), .ESC_PAT(ESC_PAT)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .fetchByte(fetchByte),
    .headIsEsc(headIsEsc), .coByte(coByte)
  );
endmodule

// File: tb/coproc_queue_tracker_tb.sv
module coproc_queue_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchValid = 1'b0;
  logic [7:0] fetchByte = 8'h00;
  logic [1:0] qStatus = 2'b00;
  logic escHit, coValid, ovfErr, udfErr;
  logic [7:0] coByte;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [1:0] S_IDLE = 2'b00, S_FIRST = 2'b01, S_FLUSH = 2'b10, S_NEXT = 2'b11;

  always #4 clk = ~clk;

  coproc_queue_tracker dut_i (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .qStatus(qStatus), .escHit(escHit), .coValid(coValid), .coByte(coByte),
    .ovfErr(ovfErr), .udfErr(udfErr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic [7:0] fb, input logic [1:0] qs);
    @(negedge clk);
    fetchValid = fv;
    fetchByte  = fb;
    qStatus    = qs;
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] fb);
    cyc(1'b1, fb, S_IDLE);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(1'b0, 8'h00, S_IDLE);
    // R10: reset state
    check("R10 escHit", escHit, 0);
    check("R10 coValid", coValid, 0);
    check("R10 ovfErr", ovfErr, 0);
    check("R10 udfErr", udfErr, 0);

    // R2/R3/R5/R7: escape instruction with two following bytes, idle cycles in between
    push(8'hD8); push(8'h11); push(8'h22);
    cyc(1'b0, 8'hFF, S_IDLE);
    check("R2 idle no output", coValid, 0);
    cyc(1'b0, 8'hFF, S_IDLE);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R3 escHit on D8", escHit, 1);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R5 coValid", coValid, 1);
    check("R5 coByte", coByte, 8'h11);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R7 match persists", coValid, 1);
    check("R1 order", coByte, 8'h22);

    // R6: non-escape instruction is dropped
    push(8'h12); push(8'h33);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R3 no escHit on 12", escHit, 0);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R6 no emit", coValid, 0);

    // R4: flush drops queued bytes and the same-cycle fetch
    push(8'h01); push(8'h02);
    cyc(1'b1, 8'h55, S_FLUSH);
    push(8'hD9); push(8'h66);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R4 head after flush", escHit, 1);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R4 byte after flush", coByte, 8'h66);
    // R4: flush clears the match
    push(8'hD8);
    cyc(1'b0, 8'h00, S_FIRST);
    cyc(1'b0, 8'h00, S_FLUSH);
    push(8'h77);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R4 match cleared", coValid, 0);

    // R7: non-matching first byte clears the match
    push(8'hD8); push(8'h10); push(8'h88);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R7 set", escHit, 1);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R7 second first", escHit, 0);
    cyc(1'b0, 8'h00, S_NEXT);
    check("R7 cleared", coValid, 0);

    // R11: full queue, pop and fetch together
    push(8'hD8);
    for (int i = 1; i <= 5; i++) push(8'hA0 + 8'(i));
    cyc(1'b1, 8'hA6, S_FIRST);
    check("R11 escHit", escHit, 1);
    check("R11 no overflow", ovfErr, 0);
    for (int i = 1; i <= 6; i++) begin
      cyc(1'b0, 8'h00, S_NEXT);
      check("R1 full order valid", coValid, 1);
      check("R1 full order byte", coByte, 8'hA0 + i);
    end

    // R3/R5/R6 sweep over every first byte
    for (int b = 0; b < 256; b++) begin
      bit expEsc;
      expEsc = (b[7:3] == 5'b11011);
      push(8'(b)); push(8'h5A ^ 8'(b));
      cyc(1'b0, 8'h00, S_FIRST);
      check("R3 sweep escHit", escHit, int'(expEsc));
      cyc(1'b0, 8'h00, S_NEXT);
      check("R5 R6 sweep coValid", coValid, int'(expEsc));
      if (expEsc) check("R5 sweep coByte", coByte, 8'h5A ^ 8'(b));
    end
    check("R9 no underflow yet", udfErr, 0);

    // R8: overflow, then R9 underflow
    push(8'hD8);
    for (int i = 1; i <= 5; i++) push(8'hB0 + 8'(i));
    check("R8 full not flagged", ovfErr, 0);
    push(8'hB6);
    check("R8 overflow", ovfErr, 1);
    cyc(1'b0, 8'h00, S_FIRST);
    for (int i = 1; i <= 5; i++) begin
      cyc(1'b0, 8'h00, S_NEXT);
      check("R8 kept byte", coByte, 8'hB0 + i);
    end
    cyc(1'b0, 8'h00, S_NEXT);
    check("R9 underflow", udfErr, 1);
    check("R9 no byte", coValid, 0);
    check("R8 dropped byte sticky", ovfErr, 1);
    cyc(1'b0, 8'h00, S_FIRST);
    check("R9 no escHit on empty", escHit, 0);
    cyc(1'b0, 8'h00, S_IDLE);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule